// File: doc/BRIEF.md
# Configurable-Frame Serial Receiver

This block takes one asynchronous serial line and recovers each frame as a parallel word. Four run-time inputs set the framing: the data length, the parity mode, the stop length and the bit rate. The block samples the line and sets the framing from these inputs at the moment a frame starts. It keeps those settings until the frame ends.

The line first passes through a synchroniser. A falling edge seen while the receiver is idle marks a possible start bit, which is checked again half a bit period later. A line that is high again at that point counts as a glitch and is dropped. Otherwise every data bit, the parity bit and each stop bit is sampled near the centre of its bit period. At the end of the frame the block loads the word and two error flags. It then raises a single-cycle valid strobe.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset the outputs show idle: `valid_o`, `busy_o`, `par_err_o`, `frm_err_o` and `data_o` are all zero.
- R2: A frame is a low start bit, then data bits least significant first, then an optional parity bit, then high stop bit(s). `data_len_i` codes 0, 1, 2, 3 select 5, 6, 7, 8 data bits. The word is right-aligned in `data_o` with the unused upper bits at zero.
- R3: `parity_i` code 1 is even parity: data plus parity bit hold an even count of ones. Code 2 is odd parity: the count is odd. Codes 0 and 3 mean no parity bit. `par_err_o` is set when the received parity does not match the mode, and it is never set without parity.
- R4: `stop_i` code 1 selects 1.5 stop bits and code 2 selects 2 stop bits. Codes 0 and 3 select 1 stop bit. `frm_err_o` is set when any sampled stop bit is low. With 2 stop bits both are sampled. With 1.5 stop bits only the first is sampled.
- R5: `valid_o` is high for exactly one cycle per received frame. `data_o`, `par_err_o` and `frm_err_o` are loaded in that cycle and hold until the next strobe.
- R6: `busy_o` is high from start detection until the frame completes. `valid_o` is asserted in the first cycle after `busy_o` falls.
- R7: A start pulse that is high again at the half-period check returns the receiver to idle and produces no strobe.
- R8: `baud_sel_i` codes 0 to 4 select 9600, 19200, 38400, 57600 and 115200 baud. Any other code selects 9600. The bit period is CLK_HZ/rate cycles, so the terminal count is one less.
- R9: The first sample is taken half a bit period after start detection, and each later sample one full period after the previous one. The frame completes at the last stop sample for 1 or 2 stop bits. For 1.5 stop bits it completes half a period after the first stop sample.
- R10: The framing and rate inputs are captured at start detection. Changes to them during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idles high |
| baud_sel_i | input | 3 | Rate select code |
| data_len_i | input | 2 | Data length code (5 to 8 bits) |
| parity_i | input | 2 | Parity mode code |
| stop_i | input | 2 | Stop length code |
| data_o | output | 8 | Received word, right-aligned |
| valid_o | output | 1 | One-cycle frame strobe |
| par_err_o | output | 1 | Parity mismatch for the last frame |
| frm_err_o | output | 1 | Low stop sample in the last frame |
| busy_o | output | 1 | Frame in progress |

## Verification
A bit index or sample counter that drifts shows up on the next strobe as a shifted word or a wrong flag. It also moves the strobe by whole or half bit periods. The bench therefore checks the cycle distance from start edge to strobe against a model built from the period and the frame layout. A wrong captured setting shows up as a wrong word or a timing offset in that same frame. A receiver stuck out of idle shows up as `busy_o` held high and missing strobes within a few bit periods.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned WORD_W        = 8;
  localparam int unsigned MIN_DATA_BITS = 5;
  localparam int unsigned NUM_RATES     = 5;
  localparam int unsigned RATE_TBL [NUM_RATES] = '{9600, 19200, 38400, 57600, 115200};

  typedef enum logic [1:0] {PM_NONE, PM_EVEN, PM_ODD} par_mode_e;
  typedef enum logic [1:0] {SM_ONE, SM_ONE_HALF, SM_TWO} stop_mode_e;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_TAIL} rx_state_e;

  typedef struct packed {
    logic [1:0] len;
    par_mode_e  par;
    stop_mode_e stop;
  } rx_cfg_t;

  function automatic par_mode_e dec_par(input logic [1:0] code);
    case (code)
      2'd1:    return PM_EVEN;
      2'd2:    return PM_ODD;
      default: return PM_NONE;
    endcase
  endfunction

  function automatic stop_mode_e dec_stop(input logic [1:0] code);
    case (code)
      2'd1:    return SM_ONE_HALF;
      2'd2:    return SM_TWO;
      default: return SM_ONE;
    endcase
  endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], rx_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign line_o = sh_q[STAGES-1];
  assign fall_o = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/rx_baud_sel.sv
module rx_baud_sel import uart_rx_pkg::*; #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned CW     = 13
) (
  input  logic [2:0]    sel_i,
  output logic [CW-1:0] full_o,
  output logic [CW-1:0] half_o
);
  logic [CW-1:0] tc_tbl [NUM_RATES];
  logic [CW:0]   period;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    assign tc_tbl[g] = CW'(CLK_HZ / RATE_TBL[g] - 1);
  end

  // unknown codes keep the slowest rate
  always_comb begin
    full_o = tc_tbl[0];
    for (int i = 0; i < NUM_RATES; i++)
      if (sel_i == 3'(i)) full_o = tc_tbl[i];
  end

  assign period = {1'b0, full_o} + (CW+1)'(1);
  assign half_o = CW'(period >> 1) - CW'(1);
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int unsigned CW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] target_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;

  assign hit_o = run_i && (cnt_q == target_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || hit_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/rx_word.sv
module rx_word #(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [IW-1:0] idx_i,
  input  logic          bit_i,
  output logic [DW-1:0] word_o
);
  for (genvar g = 0; g < DW; g++) begin : g_bit
    logic b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          b_q <= 1'b0;
      else if (clr_i)                       b_q <= 1'b0;
      else if (wr_i && idx_i == IW'(g))     b_q <= bit_i;
    end
    assign word_o[g] = b_q;
  end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx import uart_rx_pkg::*; #(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic [2:0]        baud_sel_i,
  input  logic [1:0]        data_len_i,
  input  logic [1:0]        parity_i,
  input  logic [1:0]        stop_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              busy_o
);
  localparam int unsigned CW = $clog2(CLK_HZ / RATE_TBL[0] + 1);
  localparam int unsigned IW = $clog2(WORD_W);

  rx_state_e         state_q, state_d;
  rx_cfg_t           cfg_q;
  logic [2:0]        sel_q;
  logic [IW-1:0]     idx_q;
  logic              par_bit_q, frm_acc_q;
  logic              line, fall, hit, run, start_det, last_bit, done;
  logic              frm_now, perr_now, ones;
  logic [CW-1:0]     full_tc, half_tc, target;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] data_q;
  logic              valid_q, perr_q, ferr_q;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .rx_i, .line_o(line), .fall_o(fall)
  );

  rx_baud_sel #(.CLK_HZ(CLK_HZ), .CW(CW)) u_baud (
    .sel_i(sel_q), .full_o(full_tc), .half_o(half_tc)
  );

  assign run    = (state_q != ST_IDLE);
  assign target = (state_q == ST_START ||
                   (state_q == ST_TAIL && cfg_q.stop == SM_ONE_HALF)) ? half_tc : full_tc;

  rx_bit_timer #(.CW(CW)) u_timer (
    .clk_i, .rst_ni, .run_i(run), .target_i(target), .hit_o(hit)
  );

  assign start_det = (state_q == ST_IDLE) && fall;
  assign last_bit  = (idx_q == IW'(cfg_q.len) + IW'(MIN_DATA_BITS - 1));

  rx_word #(.DW(WORD_W), .IW(IW)) u_word (
    .clk_i, .rst_ni,
    .clr_i(start_det),
    .wr_i(state_q == ST_DATA && hit),
    .idx_i(idx_q),
    .bit_i(line),
    .word_o(word)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (fall) state_d = ST_START;
      ST_START: if (hit)  state_d = line ? ST_IDLE : ST_DATA;
      ST_DATA:  if (hit && last_bit)
                  state_d = (cfg_q.par == PM_NONE) ? ST_STOP : ST_PAR;
      ST_PAR:   if (hit)  state_d = ST_STOP;
      ST_STOP:  if (hit)  state_d = (cfg_q.stop == SM_ONE) ? ST_IDLE : ST_TAIL;
      ST_TAIL:  if (hit)  state_d = ST_IDLE;
      default:            state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // framing captured once per frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{len: 2'd3, par: PM_NONE, stop: SM_ONE};
      sel_q <= 3'd0;
    end else if (start_det) begin
      cfg_q <= '{len: data_len_i, par: dec_par(parity_i), stop: dec_stop(stop_i)};
      sel_q <= baud_sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         idx_q <= '0;
    else if (start_det)                  idx_q <= '0;
    else if (state_q == ST_DATA && hit)  idx_q <= idx_q + IW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_bit_q <= 1'b0;
      frm_acc_q <= 1'b0;
    end else begin
      if (start_det)                     par_bit_q <= 1'b0;
      else if (state_q == ST_PAR && hit) par_bit_q <= line;
      if (state_q == ST_STOP && hit)     frm_acc_q <= ~line;
    end
  end

  assign done    = hit && ((state_q == ST_STOP && cfg_q.stop == SM_ONE) || state_q == ST_TAIL);
  assign frm_now = (state_q == ST_STOP) ? ~line
                                        : (frm_acc_q | ((cfg_q.stop == SM_TWO) & ~line));
  assign ones    = ^word ^ par_bit_q;

  always_comb begin
    case (cfg_q.par)
      PM_EVEN: perr_now = ones;
      PM_ODD:  perr_now = ~ones;
      default: perr_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      valid_q <= done;
      if (done) begin
        data_q <= word;
        perr_q <= perr_now;
        ferr_q <= frm_now;
      end
    end
  end

  assign data_o    = data_q;
  assign valid_o   = valid_q;
  assign par_err_o = perr_q;
  assign frm_err_o = ferr_q;
  assign busy_o    = run;
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk import uart_rx_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              busy_i,
  input logic              par_err_i,
  input logic [WORD_W-1:0] data_i,
  input logic [1:0]        len_i,
  input par_mode_e         par_i
);
  assert_valid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  assert_data_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable(data_i));

  assert_idle_on_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> !busy_i);

  assert_busy_before_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> $past(busy_i));

  assert_upper_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ((data_i >> (4'd5 + 4'(len_i))) == '0));

  assert_no_par_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && par_i == PM_NONE) |-> !par_err_i);
endmodule

bind uart_frame_rx uart_rx_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_o),
  .busy_i   (busy_o),
  .par_err_i(par_err_o),
  .data_i   (data_o),
  .len_i    (cfg_q.len),
  .par_i    (cfg_q.par)
);

// File: tb/sim_uart_frame_rx.sv
`timescale 1ns/1ps
module sim_uart_frame_rx;
  localparam int CLK_HZ_TB = 1_152_000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b1;
  logic [2:0] baud_sel_i = 3'd4;
  logic [1:0] data_len_i = 2'd3;
  logic [1:0] parity_i = 2'd0;
  logic [1:0] stop_i = 2'd0;
  logic [7:0] data_o;
  logic       valid_o, par_err_o, frm_err_o, busy_o;

  int tests = 0, fails = 0, cyc = 0;
  int vcount = 0, vcyc = 0, ref_off = -1;
  logic [7:0] vdata;
  logic vp, vf, prev_v = 1'b0;
  bit finished = 0;

  uart_frame_rx #(.CLK_HZ(CLK_HZ_TB)) u0 (
    .clk_i, .rst_ni, .rx_i, .baud_sel_i, .data_len_i, .parity_i, .stop_i,
    .data_o, .valid_o, .par_err_o, .frm_err_o, .busy_o
  );

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      vcount++; vcyc = cyc; vdata = data_o; vp = par_err_o; vf = frm_err_o;
      chk(!prev_v, "R5 strobe width", int'(prev_v), 0);
      chk(!busy_o, "R6 busy low at strobe", int'(busy_o), 0);
    end
    prev_v = valid_o;
  end

  function automatic int period_of(input int code);
    int rate;
    case (code)
      1: rate = 19200; 2: rate = 38400; 3: rate = 57600; 4: rate = 115200;
      default: rate = 9600;
    endcase
    return CLK_HZ_TB / rate;
  endfunction

  function automatic int frame_cycles(input int n, input int pm, input int sm, input int p);
    int pe = (pm == 1 || pm == 2) ? 1 : 0;
    int tail = (sm == 1) ? p / 2 : (sm == 2) ? p : 0;
    return p / 2 + (n + pe + 1) * p + tail;
  endfunction

  task automatic send_frame(input logic [7:0] d, input int lc, input int pm, input int sm,
                            input int code, input bit bpar, input bit bs1, input bit bs2,
                            input bit mut);
    int p, n, v0, t0, off;
    logic [7:0] ew;
    logic pb;
    p = period_of(code); n = lc + 5;
    ew = d & (8'hFF >> (8 - n));
    @(negedge clk_i);
    data_len_i = 2'(lc); parity_i = 2'(pm); stop_i = 2'(sm); baud_sel_i = 3'(code);
    v0 = vcount; t0 = cyc; rx_i = 1'b0;
    for (int i = 0; i < p; i++) begin
      if (mut && i == 3) begin  // R10: inputs move mid-frame
        data_len_i = 2'd0; parity_i = 2'd1; stop_i = 2'd2; baud_sel_i = 3'd0;
      end
      @(negedge clk_i);
    end
    for (int b = 0; b < n; b++) begin
      rx_i = ew[b];
      if (b == 0) begin
        repeat (p / 2) @(negedge clk_i);
        chk(busy_o, "R6 busy during frame", int'(busy_o), 1);
        repeat (p - p / 2) @(negedge clk_i);
      end else repeat (p) @(negedge clk_i);
    end
    if (pm == 1 || pm == 2) begin
      pb = (^ew) ^ (pm == 2) ^ bpar;
      rx_i = pb; repeat (p) @(negedge clk_i);
    end
    rx_i = ~bs1; repeat (p) @(negedge clk_i);
    if (sm == 1) begin rx_i = 1'b1; repeat (p / 2) @(negedge clk_i); end
    if (sm == 2) begin rx_i = ~bs2; repeat (p) @(negedge clk_i); end
    rx_i = 1'b1;
    repeat (3 * p) @(negedge clk_i);
    chk(vcount == v0 + 1, "R5 one strobe per frame", vcount - v0, 1);
    chk(vdata == ew, "R2 word", vdata, ew);
    chk(vp == (bpar && (pm == 1 || pm == 2)), "R3 parity flag", vp, int'(bpar && (pm == 1 || pm == 2)));
    chk(vf == (bs1 || (sm == 2 && bs2)), "R4 framing flag", vf, int'(bs1 || (sm == 2 && bs2)));
    off = (vcyc - t0) - frame_cycles(n, pm, sm, p);
    if (ref_off < 0) begin
      ref_off = off;
      chk(off >= 1 && off <= 8, "R9 latency offset", off, 4);
    end else chk(off == ref_off, "R9/R8 frame timing", off, ref_off);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk_i);
    chk(!valid_o && !busy_o, "R1 idle strobe/busy", int'({valid_o, busy_o}), 0);
    chk(data_o == 8'h00, "R1 data", data_o, 0);
    chk(!par_err_o && !frm_err_o, "R1 flags", int'({par_err_o, frm_err_o}), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(!busy_o && !valid_o, "R1 idle after reset", int'({valid_o, busy_o}), 0);

    send_frame(8'hA5, 3, 0, 0, 4, 0, 0, 0, 0);   // 8N1 reference
    send_frame(8'hFF, 0, 1, 0, 4, 0, 0, 0, 0);   // R2 5 bits, upper zero
    send_frame(8'h3C, 1, 2, 1, 4, 1, 0, 0, 0);   // R3 odd error, R4 1.5 stop
    send_frame(8'h81, 2, 1, 2, 3, 1, 0, 1, 0);   // R3 even error, R4 second stop low
    send_frame(8'h5A, 3, 3, 3, 4, 1, 1, 0, 0);   // R3/R4 reserved codes
    send_frame(8'hC3, 3, 0, 0, 7, 0, 0, 0, 0);   // R8 fallback rate
    send_frame(8'h96, 3, 0, 0, 0, 0, 0, 0, 0);   // R8 slowest rate
    send_frame(8'hE7, 3, 0, 0, 4, 0, 0, 0, 1);   // R10 mid-frame change

    begin  // R7 short start pulse
      int v0; bit seen;
      @(negedge clk_i); baud_sel_i = 3'd4; v0 = vcount; seen = 0;
      rx_i = 1'b0; repeat (2) @(negedge clk_i); rx_i = 1'b1;
      for (int i = 0; i < 8; i++) begin @(negedge clk_i); if (busy_o) seen = 1; end
      repeat (200) @(negedge clk_i);
      chk(seen, "R7 glitch seen as start", int'(seen), 1);
      chk(vcount == v0, "R7 no strobe", vcount - v0, 0);
      chk(!busy_o, "R7 back to idle", int'(busy_o), 0);
    end

    for (int k = 0; k < 40; k++) begin
      int code = int'($urandom % 8);
      if ($urandom % 4 != 0) code = 3 + int'($urandom % 2);
      send_frame(8'($urandom), int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
                 code, ($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 3) == 0, 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule